// File: doc/BRIEF.md
# Tetrahedron Wireframe Edge Rasterizer

This block turns four projected corner positions of a tetrahedron into pixel writes for an off-screen frame store. A start strobe captures the four positions. The block then blanks the whole square frame store, one address per clock. After that it draws the six edges that join every pair of corners, one after another, with an integer Bresenham stepper. The stepper emits one pixel per clock. When the last pixel of the last edge has been written, the block gives a one-cycle completion pulse.

Each position is packed into `2*COORD_W` bits: the column sits in the upper half and the row in the lower half. With the default `COORD_W = 8`, the frame store is 256 by 256 and the write address is `row*256 + column`. Blank pixels carry the value zero and drawn pixels carry all ones. Presenting the frame and swapping buffers is the job of the surrounding logic.

Top module: `wf_edge_rasterizer`

## Requirements
- R1: While reset is held, and on the first clock after it is released, `wr_en` and `done` are 0.
- R2: Each vertex input carries its column in bits [2*COORD_W-1:COORD_W] and its row in bits [COORD_W-1:0].
- R3: After an accepted start, the first 2^(2*COORD_W) writes go to addresses 0, 1, 2, … in ascending order with data 0, on consecutive clocks, and they come before any edge pixel.
- R4: A pixel at column x and row y is written at address y*2^COORD_W + x, with data all ones.
- R5: Edges are drawn in the corner-pair order (0,1), (0,2), (0,3), (1,2), (1,3), (2,3).
- R6: Each edge writes exactly the Bresenham pixel sequence from its first corner to its second, in every octant. The sequence includes both endpoints, and each step moves at most one pixel in each axis.
- R7: Within one edge, successive pixels are written on successive clocks.
- R8: `done` pulses for exactly one clock after the last pixel of edge (2,3), and no write occurs from then until the next accepted start.
- R9: A start strobe that arrives while a frame is in progress is ignored, and vertex input changes after the accepted start do not affect the frame.
- R10: An edge whose two corners coincide writes exactly one pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| vtx0 | input | 2*COORD_W | Corner 0, column high / row low |
| vtx1 | input | 2*COORD_W | Corner 1 |
| vtx2 | input | 2*COORD_W | Corner 2 |
| vtx3 | input | 2*COORD_W | Corner 3 |
| wr_en | output | 1 | Frame store write strobe |
| wr_addr | output | 2*COORD_W | Frame store write address |
| wr_data | output | PIX_W | Pixel value written |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that reset is applied before the first start and that every corner lies inside the square grid. Packing guarantees the second condition for any input bit pattern, so the stimulus draws whole corner words from a seeded $urandom without filtering. The first assumption holds because the bench releases reset before any frame. Directed frames add coincident corners, axis-aligned edges, steep and shallow diagonals, and grid extremes. A start pulse with altered corners is injected during the clear phase and again during edge drawing, to confirm that the latched frame is unchanged.

// File: rtl/wfr_pkg.sv
package wfr_pkg;
   typedef enum logic [1:0] {PH_IDLE, PH_CLEAR, PH_LOAD, PH_LINE} phase_t;

   localparam int N_CORNER = 4;
   localparam int N_EDGE   = 6;
   localparam int EDGE_IW  = 3;

   // first corner of edge e; edge list (0,1)(0,2)(0,3)(1,2)(1,3)(2,3)
   function automatic logic [1:0] edge_from(input logic [EDGE_IW-1:0] e);
      case (e)
         3'd0, 3'd1, 3'd2: edge_from = 2'd0;
         3'd3, 3'd4:       edge_from = 2'd1;
         default:          edge_from = 2'd2;
      endcase
   endfunction

   function automatic logic [1:0] edge_to(input logic [EDGE_IW-1:0] e);
      case (e)
         3'd0:       edge_to = 2'd1;
         3'd1, 3'd3: edge_to = 2'd2;
         default:    edge_to = 2'd3;
      endcase
   endfunction
endpackage

// File: rtl/wf_edge_pick.sv
module wf_edge_pick #(
   parameter int COORD_W = 8
) (
   input  logic [4*2*COORD_W-1:0] corners,
   input  logic [2:0]             edge_idx,
   output logic [COORD_W-1:0]     xa,
   output logic [COORD_W-1:0]     ya,
   output logic [COORD_W-1:0]     xb,
   output logic [COORD_W-1:0]     yb
);
   import wfr_pkg::*;
   localparam int PW = 2 * COORD_W;

   logic [COORD_W-1:0] cx [N_CORNER];
   logic [COORD_W-1:0] cy [N_CORNER];

   for (genvar g = 0; g < N_CORNER; g++) begin : g_unpack
      assign cx[g] = corners[g*PW + COORD_W +: COORD_W];
      assign cy[g] = corners[g*PW +: COORD_W];
   end

   logic [1:0] ia, ib;
   always_comb begin
      ia = edge_from(edge_idx);
      ib = edge_to(edge_idx);
      xa = cx[ia];
      ya = cy[ia];
      xb = cx[ib];
      yb = cy[ib];
   end
endmodule

// File: rtl/bres_line.sv
module bres_line #(
   parameter int COORD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [COORD_W-1:0] x0,
   input  logic [COORD_W-1:0] y0,
   input  logic [COORD_W-1:0] x1,
   input  logic [COORD_W-1:0] y1,
   output logic               valid,
   output logic [COORD_W-1:0] px,
   output logic [COORD_W-1:0] py,
   output logic               last
);
   localparam int EW = COORD_W + 3;

   logic                 active;
   logic [COORD_W-1:0]   xe, ye;
   logic signed [EW-1:0] dx, dy, err;
   logic                 sx_neg, sy_neg;

   logic signed [EW-1:0] sdx, sdy, adx, ady, e2, err_n;
   logic                 step_x, step_y;

   always_comb begin
      sdx = $signed({3'b000, x1}) - $signed({3'b000, x0});
      sdy = $signed({3'b000, y1}) - $signed({3'b000, y0});
      adx = sdx[EW-1] ? -sdx : sdx;
      ady = sdy[EW-1] ? -sdy : sdy;
      e2     = err <<< 1;
      step_x = (e2 >= dy);
      step_y = (e2 <= dx);
      err_n  = err + (step_x ? dy : '0) + (step_y ? dx : '0);
      last   = active && (px == xe) && (py == ye);
      valid  = active;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         px <= '0; py <= '0; xe <= '0; ye <= '0;
         dx <= '0; dy <= '0; err <= '0;
         sx_neg <= 1'b0; sy_neg <= 1'b0;
      end else if (go) begin
         active <= 1'b1;
         px <= x0; py <= y0; xe <= x1; ye <= y1;
         dx <= adx;
         dy <= -ady;
         err <= adx - ady;
         sx_neg <= sdx[EW-1];
         sy_neg <= sdy[EW-1];
      end else if (active) begin
         if (last) begin
            active <= 1'b0;
         end else begin
            err <= err_n;
            if (step_x) px <= sx_neg ? px - 1'b1 : px + 1'b1;
            if (step_y) py <= sy_neg ? py - 1'b1 : py + 1'b1;
         end
      end
   end

   // R6: a finished line stops stepping
   p_line_stops_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (last && !go) |=> !active);
   // R6: every non-final step moves, by at most one in each axis
   p_step_unit_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (active && !last && !go) |=> active &&
         ((px != $past(px)) || (py != $past(py))) &&
         ((px - $past(px) == 1) || ($past(px) - px == 1) || (px == $past(px))) &&
         ((py - $past(py) == 1) || ($past(py) - py == 1) || (py == $past(py))));
endmodule

// File: rtl/wf_edge_rasterizer.sv
module wf_edge_rasterizer #(
   parameter int COORD_W = 8,
   parameter int PIX_W   = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [2*COORD_W-1:0] vtx0,
   input  logic [2*COORD_W-1:0] vtx1,
   input  logic [2*COORD_W-1:0] vtx2,
   input  logic [2*COORD_W-1:0] vtx3,
   output logic                 wr_en,
   output logic [2*COORD_W-1:0] wr_addr,
   output logic [PIX_W-1:0]     wr_data,
   output logic                 done
);
   import wfr_pkg::*;
   localparam int AW = 2 * COORD_W;
   localparam logic [AW-1:0]      CLR_LAST  = '1;
   localparam logic [EDGE_IW-1:0] EDGE_LAST = EDGE_IW'(N_EDGE - 1);
   localparam logic [PIX_W-1:0]   INK       = '1;

   initial begin : elab_check
      assert (COORD_W >= 2 && COORD_W <= 12);
      assert (PIX_W >= 1 && PIX_W <= 32);
   end

   phase_t               phase;
   logic [4*AW-1:0]      held;
   logic [AW-1:0]        clr_cnt;
   logic [EDGE_IW-1:0]   edge_idx;
   logic [COORD_W-1:0]   xa, ya, xb, yb, px, py;
   logic                 ln_go, ln_valid, ln_last;

   wf_edge_pick #(.COORD_W(COORD_W)) u_pick (
      .corners(held), .edge_idx(edge_idx),
      .xa(xa), .ya(ya), .xb(xb), .yb(yb)
   );

   assign ln_go = (phase == PH_LOAD);

   bres_line #(.COORD_W(COORD_W)) u_line (
      .clk(clk), .rst_n(rst_n), .go(ln_go),
      .x0(xa), .y0(ya), .x1(xb), .y1(yb),
      .valid(ln_valid), .px(px), .py(py), .last(ln_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         held     <= '0;
         clr_cnt  <= '0;
         edge_idx <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (phase)
            PH_IDLE: if (start) begin
               held    <= {vtx3, vtx2, vtx1, vtx0};
               clr_cnt <= '0;
               phase   <= PH_CLEAR;
            end
            PH_CLEAR: begin
               clr_cnt <= clr_cnt + 1'b1;
               if (clr_cnt == CLR_LAST) begin
                  edge_idx <= '0;
                  phase    <= PH_LOAD;
               end
            end
            PH_LOAD: phase <= PH_LINE;
            default: if (ln_last) begin
               if (edge_idx == EDGE_LAST) begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end else begin
                  edge_idx <= edge_idx + 1'b1;
                  phase    <= PH_LOAD;
               end
            end
         endcase
      end
   end

   generate
      if (PIX_W == 1) begin : g_mono
         assign wr_data = (phase == PH_CLEAR) ? 1'b0 : 1'b1;
      end else begin : g_wide
         assign wr_data = (phase == PH_CLEAR) ? '0 : INK;
      end
   endgenerate

   always_comb begin
      wr_en   = (phase == PH_CLEAR) || (phase == PH_LINE && ln_valid);
      wr_addr = (phase == PH_CLEAR) ? clr_cnt : {py, px};
   end

   // R3: clear addresses advance by one each clock
   p_clear_step_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CLEAR && $past(phase) == PH_CLEAR) |-> wr_addr == $past(wr_addr) + 1'b1);
   // R3: clearing writes zero
   p_clear_zero_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CLEAR) |-> (wr_en && wr_data == '0));
   // R8: completion is a single-cycle pulse
   p_done_pulse_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8: idle block never writes
   p_idle_quiet_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> !wr_en);
   // R9: latched corners hold while busy
   p_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(held));
endmodule

// File: tb/wf_edge_rasterizer_test.sv
module wf_edge_rasterizer_test;
   localparam int CW = 6;
   localparam int PW = 2 * CW;
   localparam int NPIX = 1 << (2 * CW);

   logic clk = 0, rst_n = 0, start = 0;
   logic [PW-1:0] vtx0 = '0, vtx1 = '0, vtx2 = '0, vtx3 = '0;
   logic wr_en, done;
   logic [PW-1:0] wr_addr;
   logic [0:0] wr_data;

   wf_edge_rasterizer #(.COORD_W(CW), .PIX_W(1)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .vtx0(vtx0), .vtx1(vtx1), .vtx2(vtx2), .vtx3(vtx3),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
   );

   always #4 clk = ~clk;

   int total = 0, bad = 0, cyc = 0, done_cnt = 0;
   int act_a[$], act_d[$], act_c[$];
   int exp_a[$], exp_d[$], exp_k[$]; // exp_k: 1 = must follow previous write by one clock

   always @(negedge clk) begin
      cyc++;
      if (wr_en) begin
         act_a.push_back(int'(wr_addr));
         act_d.push_back(int'(wr_data));
         act_c.push_back(cyc);
      end
      if (done) done_cnt++;
      if (cyc > 190000) begin
         bad++; total++;
         $display("FAIL watchdog: actual cyc=%0d expected < 190000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic int ax(input logic [PW-1:0] p); return int'(p[PW-1:CW]); endfunction
   function automatic int ay(input logic [PW-1:0] p); return int'(p[CW-1:0]); endfunction

   task automatic model_line(input int x0, input int y0, input int x1, input int y1);
      int dx = (x1 > x0) ? x1 - x0 : x0 - x1;
      int dy = (y1 > y0) ? y0 - y1 : y1 - y0;
      int sx = (x1 > x0) ? 1 : -1;
      int sy = (y1 > y0) ? 1 : -1;
      int err = dx + dy;
      int x = x0, y = y0, first = 1;
      forever begin
         exp_a.push_back(y * (1 << CW) + x);
         exp_d.push_back(1);
         exp_k.push_back(first ? 0 : 1);
         first = 0;
         if (x == x1 && y == y1) break;
         begin
            int e2 = 2 * err;
            if (e2 >= dy) begin err += dy; x += sx; end
            if (e2 <= dx) begin err += dx; y += sy; end
         end
      end
   endtask

   task automatic model_frame(input logic [PW-1:0] p [4]);
      int fa[6] = '{0, 0, 0, 1, 1, 2};
      int fb[6] = '{1, 2, 3, 2, 3, 3};
      exp_a.delete(); exp_d.delete(); exp_k.delete();
      for (int i = 0; i < NPIX; i++) begin
         exp_a.push_back(i); exp_d.push_back(0); exp_k.push_back(i == 0 ? 0 : 1);
      end
      for (int e = 0; e < 6; e++)
         model_line(ax(p[fa[e]]), ay(p[fa[e]]), ax(p[fb[e]]), ay(p[fb[e]]));
   endtask

   task automatic check(input bit ok, input string req, input string what, input int a, input int e);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, a, e);
      end
   endtask

   // inject: 0 none, 1 restart during clear, 2 restart during drawing
   task automatic run_frame(input logic [PW-1:0] p [4], input int inject, input string tag);
      int to, n, mis, gap;
      model_frame(p);
      act_a.delete(); act_d.delete(); act_c.delete();
      done_cnt = 0;
      @(negedge clk);
      vtx0 = p[0]; vtx1 = p[1]; vtx2 = p[2]; vtx3 = p[3];
      start = 1;
      @(negedge clk);
      start = 0;
      to = 0;
      while (!done && to < NPIX + 4000) begin
         @(negedge clk);
         to++;
         if (inject == 1 && to == 50) begin
            vtx0 = ~p[0]; vtx1 = ~p[1]; vtx2 = p[3]; vtx3 = p[2]; start = 1;
         end else if (inject == 2 && to == NPIX + 5) begin
            vtx0 = p[3]; vtx1 = ~p[2]; vtx2 = ~p[1]; vtx3 = p[0]; start = 1;
         end else begin
            start = 0;
         end
      end
      start = 0;
      check(done == 1, "R8", {tag, " done seen"}, int'(done), 1);
      n = act_a.size();
      repeat (40) @(negedge clk);
      check(act_a.size() == n, "R8", {tag, " writes after done"}, act_a.size(), n);
      check(done_cnt == 1, "R8", {tag, " done pulse count"}, done_cnt, 1);
      check(act_a.size() == exp_a.size(), "R6", {tag, " write count"}, act_a.size(), exp_a.size());
      mis = -1;
      for (int i = 0; i < act_a.size() && i < exp_a.size(); i++)
         if (act_a[i] != exp_a[i] || act_d[i] != exp_d[i]) begin mis = i; break; end
      if (mis < 0) check(1, "R3", {tag, " sequence"}, 0, 0);
      else check(0, (mis < NPIX) ? "R3" : "R5/R6", {tag, " write addr at index"},
                 act_a[mis] * 2 + act_d[mis], exp_a[mis] * 2 + exp_d[mis]);
      gap = -1;
      for (int i = 1; i < act_c.size() && i < exp_k.size(); i++)
         if (exp_k[i] == 1 && act_c[i] != act_c[i-1] + 1) begin gap = i; break; end
      check(gap < 0, "R7", {tag, " consecutive writes"}, gap, -1);
   endtask

   initial begin
      logic [PW-1:0] p [4];
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      check(wr_en == 0 && done == 0, "R1", "outputs in reset", {wr_en, done}, 0);
      rst_n = 1;
      @(negedge clk);
      check(wr_en == 0 && done == 0, "R1", "outputs after reset", {wr_en, done}, 0);

      // R10/R2/R4: all corners equal, column 5 row 40 -> six single pixels at 40*64+5
      p = '{ {6'd5, 6'd40}, {6'd5, 6'd40}, {6'd5, 6'd40}, {6'd5, 6'd40} };
      run_frame(p, 0, "R10 coincident");
      check(exp_a.size() == NPIX + 6 && act_a.size() == NPIX + 6 && act_a[NPIX] == 40*64+5,
            "R2", "packing/address of pixel", act_a.size() > NPIX ? act_a[NPIX] : -1, 40*64+5);
      // R6: extremes, axis-aligned and steep/shallow in all directions
      p = '{ {6'd0, 6'd0}, {6'd63, 6'd63}, {6'd63, 6'd0}, {6'd0, 6'd63} };
      run_frame(p, 0, "R6 corners");
      p = '{ {6'd10, 6'd30}, {6'd12, 6'd2}, {6'd50, 6'd33}, {6'd9, 6'd31} };
      run_frame(p, 1, "R9 restart in clear");
      p = '{ {6'd40, 6'd8}, {6'd3, 6'd20}, {6'd41, 6'd60}, {6'd40, 6'd8} };
      run_frame(p, 2, "R9 restart in draw");
      for (int k = 0; k < 6; k++) begin
         for (int j = 0; j < 4; j++) p[j] = PW'($urandom);
         run_frame(p, 0, "R5 random");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule